// File: doc/BRIEF.md
# Write-Protected Two-Wire Wiper Register Controller

This block is a two-wire serial slave that owns a small set of wiper position registers, each backed by a shadow register that stands in for nonvolatile storage, plus one control/status register holding two write-enable latches and a wiper write-lock bit. A host reaches it through a frame of three bytes: a slave address with a read/write bit, an instruction byte that picks the register, and one data byte. Reads use a repeated START after the address and instruction.

Wiper writes come in two kinds. A volatile write moves only the live wiper value. A nonvolatile write moves both the wiper and its shadow copy, and at the following STOP the block enters a fixed-length busy period. During that period it refuses its own address, so the host can poll for completion. Writes pass through several layers of protection: an enable latch, a second latch that guards the control register, a lock bit that freezes every wiper, and a hardware protect pin.

SDA and SCL are oversampled by the system clock. The block drives SDA only through an open-drain pull-down request.

Top module: `twi_wiper_ctrl`

## Requirements
- R1: START (SDA falls while SCL is high) begins a frame. The first byte is acknowledged only when its upper seven bits equal SLV_ADDR (default 0x2C, so 0x58 writes and 0x59 reads). SDA is driven only while SCL is low.
- R2: After reset, wiper i and shadow i both hold RST_POS[i*8 +: 8] (default wiper 0 = 0x20, wiper 1 = 0x40). The control register reads 0, busy is low and SDA is released.
- R3: Instruction bits [7:6]=00 with bit 0 selecting the wiper is a volatile write. It changes that wiper only, and a read of the shadow returns its old value.
- R4: Instruction bits [7:6]=01 is a nonvolatile write. It changes both the wiper and its shadow. At the next STOP, busy rises and stays high for exactly NV_CYCLES clock cycles.
- R5: While busy is high, the block does not acknowledge its address, and no register changes.
- R6: In a write frame only the first data byte is acknowledged. Any later bytes are not acknowledged and have no effect.
- R7: A wiper write with the enable latch clear is acknowledged but leaves the wiper unchanged.
- R8: Instruction bits [7:6]=10 addresses the control register, with bit 0 the enable latch, bit 1 the register-write latch and bit 2 the lock bit. Data rules: 0x00 clears both latches. Data with bit 1 set sets the register-write latch only if the enable latch is set. With both latches set, any other data loads the lock bit from data bit 2, clears the register-write latch and starts a busy period at STOP. Otherwise, data bit 0 sets the enable latch. Latch-only writes never start a busy period.
- R9: While the lock bit is set, wiper writes are acknowledged and ignored.
- R10: While the protect pin is high, wiper writes and lock-bit writes are ignored, but the enable latches still respond.
- R11: A random read returns the wiper, the shadow or the control register selected by the instruction byte. Instructions whose bits [5:1] are not zero read 0 and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | High to pull SDA low |
| wprot_i | input | 1 | Hardware write protect, high blocks |
| wiper_o | output | NUM_DCP*WIPER_W | Live wiper positions, wiper i at [i*WIPER_W +: WIPER_W] |
| nv_busy_o | output | 1 | Nonvolatile cycle in progress |

## Verification
Every line event takes effect three clock cycles after the pin moves: two cycles in the synchronizer and one in the state register. The pull-down for an acknowledge or a read bit therefore appears three cycles after SCL falls. A register update appears three cycles after the eighth SCL rise of the data byte, and busy rises about four cycles after the SDA edge of STOP. The bench holds each line level for five cycles and samples at falling clock edges, two quarter-periods after each SCL fall. That puts every sample well clear of these latencies. The bench checks the busy length exactly by counting busy-high cycles at falling edges over the whole window.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_INSTR,
    BK_DATA,
    BK_EXTRA
  } byte_kind_e;

  localparam logic [1:0] TGT_VOL  = 2'b00;
  localparam logic [1:0] TGT_NV   = 2'b01;
  localparam logic [1:0] TGT_CTRL = 2'b10;

  localparam int CTL_WEL  = 0;
  localparam int CTL_RWEL = 1;
  localparam int CTL_LOCK = 2;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wprot_i,
  output logic scl_s,
  output logic sda_s,
  output logic wprot_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_stb,
  output logic stop_stb
);

  logic scl_m, scl_q, scl_p;
  logic sda_m, sda_q, sda_p;
  logic wp_m, wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_m <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
      wp_m  <= 1'b0;
      wp_q  <= 1'b0;
    end else begin
      scl_m <= scl_i;
      scl_q <= scl_m;
      scl_p <= scl_q;
      sda_m <= sda_i;
      sda_q <= sda_m;
      sda_p <= sda_q;
      wp_m  <= wprot_i;
      wp_q  <= wp_m;
    end
  end

  assign scl_s     = scl_q;
  assign sda_s     = sda_q;
  assign wprot_s   = wp_q;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_stb = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_stb  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_regs_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_stb,
  input  logic       stop_stb,
  input  logic       busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pull_o,
  output logic       wr_stb_o,
  output logic [7:0] instr_o,
  output logic [7:0] wr_data_o
);

  twi_state_e st_q, st_n;
  byte_kind_e kind_q, kind_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [7:0] instr_q, instr_n;
  logic       rw_q, rw_n;
  logic       ack_q, ack_n;
  logic       pull_q, pull_n;
  logic [7:0] rx_byte;
  logic       last_bit;

  assign rx_byte  = {sh_q[6:0], sda_s};
  assign last_bit = (cnt_q == 4'd7);

  always_comb begin
    st_n    = st_q;
    kind_n  = kind_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    instr_n = instr_q;
    rw_n    = rw_q;
    ack_n   = ack_q;
    pull_n  = pull_q;
    if (start_stb) begin
      st_n   = ST_RX;
      kind_n = BK_ADDR;
      cnt_n  = 4'd0;
      pull_n = 1'b0;
    end else if (stop_stb) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          sh_n  = rx_byte;
          cnt_n = cnt_q + 4'd1;
          if (last_bit) begin
            st_n = ST_ACKW;
            case (kind_q)
              BK_ADDR: begin
                ack_n = (rx_byte[7:1] == SLV_ADDR) && !busy_i;
                rw_n  = rx_byte[0];
              end
              BK_INSTR: begin
                ack_n   = 1'b1;
                instr_n = rx_byte;
              end
              BK_DATA: ack_n = 1'b1;
              default: ack_n = 1'b0;
            endcase
          end
        end
        ST_ACKW: if (scl_fall) begin
          pull_n = ack_q;
          st_n   = ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          pull_n = 1'b0;
          cnt_n  = 4'd0;
          if (!ack_q) begin
            st_n = ST_IDLE;
          end else begin
            case (kind_q)
              BK_ADDR: begin
                if (rw_q) begin
                  st_n   = ST_TX;
                  pull_n = ~rd_data_i[7];
                  sh_n   = {rd_data_i[6:0], 1'b0};
                  cnt_n  = 4'd1;
                end else begin
                  st_n   = ST_RX;
                  kind_n = BK_INSTR;
                end
              end
              BK_INSTR: begin
                st_n   = ST_RX;
                kind_n = BK_DATA;
              end
              default: begin
                st_n   = ST_RX;
                kind_n = BK_EXTRA;
              end
            endcase
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            pull_n = 1'b0;
            st_n   = ST_MACK;
          end else begin
            pull_n = ~sh_q[7];
            sh_n   = {sh_q[6:0], 1'b0};
            cnt_n  = cnt_q + 4'd1;
          end
        end
        ST_MACK: if (scl_rise) st_n = ST_IDLE;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= 4'd0;
      sh_q    <= 8'h00;
      instr_q <= 8'h00;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      instr_q <= instr_n;
      rw_q    <= rw_n;
      ack_q   <= ack_n;
      pull_q  <= pull_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign instr_o    = instr_q;
  assign wr_data_o  = rx_byte;
  assign wr_stb_o   = (st_q == ST_RX) && scl_rise && last_bit && (kind_q == BK_DATA);

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_s); // R1

  AST_EXTRA_BYTE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK && kind_q == BK_EXTRA) |-> !pull_q); // R6

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_regs_pkg::*;
#(
  parameter int NUM_DCP = 2,
  parameter int WIPER_W = 8,
  parameter logic [NUM_DCP*WIPER_W-1:0] RST_POS = '0,
  parameter int NV_CYCLES = 2000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb_i,
  input  logic [7:0]                 instr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic                       stop_stb_i,
  input  logic                       wprot_i,
  output logic [7:0]                 rd_data_o,
  output logic                       busy_o,
  output logic [NUM_DCP*WIPER_W-1:0] wiper_o
);

  localparam int SEL_W = (NUM_DCP > 1) ? $clog2(NUM_DCP) : 1;
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES - 1);

  logic [1:0]       tgt;
  logic [SEL_W-1:0] sel;
  logic             rsvd_ok;
  logic             wiper_ok, wiper_we, shadow_we, ctl_we, lock_nv;
  logic             wel_q, wel_n, rwel_q, rwel_n, lock_q, lock_n;
  logic             pend_q, pend_n, busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NUM_DCP*WIPER_W-1:0] shadow_flat;

  assign tgt       = instr_i[7:6];
  assign sel       = instr_i[SEL_W-1:0];
  assign rsvd_ok   = (instr_i[5:SEL_W] == '0);
  assign wiper_ok  = wel_q & ~lock_q & ~wprot_i;
  assign wiper_we  = wr_stb_i & rsvd_ok & ~tgt[1] & wiper_ok;
  assign shadow_we = wiper_we & (tgt == TGT_NV);
  assign ctl_we    = wr_stb_i & rsvd_ok & (tgt == TGT_CTRL);

  always_comb begin
    wel_n   = wel_q;
    rwel_n  = rwel_q;
    lock_n  = lock_q;
    lock_nv = 1'b0;
    if (ctl_we) begin
      if (wr_data_i == 8'h00) begin
        wel_n  = 1'b0;
        rwel_n = 1'b0;
      end else if (wr_data_i[CTL_RWEL]) begin
        rwel_n = wel_q;
      end else if (wel_q && rwel_q) begin
        rwel_n = 1'b0;
        if (!wprot_i) begin
          lock_n  = wr_data_i[CTL_LOCK];
          lock_nv = 1'b1;
        end
      end else begin
        wel_n = wel_q | wr_data_i[CTL_WEL];
      end
    end
  end

  always_comb begin
    pend_n = pend_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (stop_stb_i) pend_n = 1'b0;
    else if (shadow_we || lock_nv) pend_n = 1'b1;
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else cnt_n = cnt_q - 1'b1;
    end else if (stop_stb_i && pend_q) begin
      busy_n = 1'b1;
      cnt_n  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      lock_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      wel_q  <= wel_n;
      rwel_q <= rwel_n;
      lock_q <= lock_n;
      pend_q <= pend_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  for (genvar g = 0; g < NUM_DCP; g++) begin : g_dcp
    logic               hit;
    logic [WIPER_W-1:0] wip_q, wip_n, shd_q, shd_n;

    assign hit = (sel == SEL_W'(g));

    always_comb begin
      wip_n = wip_q;
      shd_n = shd_q;
      if (wiper_we && hit)  wip_n = wr_data_i[WIPER_W-1:0];
      if (shadow_we && hit) shd_n = wr_data_i[WIPER_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wip_q <= RST_POS[g*WIPER_W +: WIPER_W];
        shd_q <= RST_POS[g*WIPER_W +: WIPER_W];
      end else begin
        wip_q <= wip_n;
        shd_q <= shd_n;
      end
    end

    assign wiper_o[g*WIPER_W +: WIPER_W]     = wip_q;
    assign shadow_flat[g*WIPER_W +: WIPER_W] = shd_q;
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (rsvd_ok) begin
      case (tgt)
        TGT_VOL:  rd_data_o[WIPER_W-1:0] = wiper_o[int'(sel)*WIPER_W +: WIPER_W];
        TGT_NV:   rd_data_o[WIPER_W-1:0] = shadow_flat[int'(sel)*WIPER_W +: WIPER_W];
        TGT_CTRL: rd_data_o = {5'b00000, lock_q, rwel_q, wel_q};
        default:  rd_data_o = 8'h00;
      endcase
    end
  end

  assign busy_o = busy_q;

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !wr_stb_i); // R5

  AST_VOL_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && tgt == TGT_VOL) |=> $stable(shadow_flat)); // R3

  AST_NO_WEL_NO_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && !tgt[1] && !wel_q) |=> $stable(wiper_o)); // R7

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && !tgt[1] && lock_q) |=> $stable(wiper_o)); // R9

  AST_PIN_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && !tgt[1] && wprot_i) |=> $stable(wiper_o) && $stable(lock_q)); // R10

  AST_LATCH_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb_i && !busy_q && !pend_q) |=> !busy_q); // R8

endmodule

// File: rtl/twi_wiper_ctrl.sv
module twi_wiper_ctrl #(
  parameter logic [6:0] SLV_ADDR = 7'h2C,
  parameter int NUM_DCP = 2,
  parameter int WIPER_W = 8,
  parameter logic [NUM_DCP*WIPER_W-1:0] RST_POS = 16'h4020,
  parameter int NV_CYCLES = 2000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  input  logic                       wprot_i,
  output logic [NUM_DCP*WIPER_W-1:0] wiper_o,
  output logic                       nv_busy_o
);

  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic       scl_s, sda_s, wprot_s, scl_rise, scl_fall, start_stb, stop_stb;
  logic       busy, wr_stb;
  logic [7:0] instr, wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  twi_line_sync i_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .wprot_i   (wprot_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .wprot_s   (wprot_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_stb (start_stb),
    .stop_stb  (stop_stb)
  );

  twi_slave_fsm #(.SLV_ADDR(SLV_ADDR)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_ns),
    .scl_s      (scl_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .start_stb  (start_stb),
    .stop_stb   (stop_stb),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .sda_pull_o (sda_pull_o),
    .wr_stb_o   (wr_stb),
    .instr_o    (instr),
    .wr_data_o  (wr_data)
  );

  twi_reg_bank #(
    .NUM_DCP   (NUM_DCP),
    .WIPER_W   (WIPER_W),
    .RST_POS   (RST_POS),
    .NV_CYCLES (NV_CYCLES)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_stb_i   (wr_stb),
    .instr_i    (instr),
    .wr_data_i  (wr_data),
    .stop_stb_i (stop_stb),
    .wprot_i    (wprot_s),
    .rd_data_o  (rd_data),
    .busy_o     (busy),
    .wiper_o    (wiper_o)
  );

  assign nv_busy_o = busy;

endmodule

// File: tb/test_twi_wiper_ctrl.sv
`timescale 1ns/1ps
module test_twi_wiper_ctrl;

  localparam int NV = 400;
  localparam int Q  = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m, wprot;
  wire         sda_pull;
  wire  [15:0] wiper;
  wire         nv_busy;
  wire         sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int total_busy = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(negedge clk) if (nv_busy) total_busy <= total_busy + 1;

  twi_wiper_ctrl #(.NV_CYCLES(NV)) i_twi_wiper_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .wprot_i    (wprot),
    .wiper_o    (wiper),
    .nv_busy_o  (nv_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic tw_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic tw_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw();
    sda_m = 1'b1; qw(); qw();
  endtask

  task automatic tw_wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = !sda_line;
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic tw_rd(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0;
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic xfer_wr(input logic [7:0] ins, input logic [7:0] dat, output bit dack);
    bit a;
    tw_start(); tw_wr(8'h58, a); tw_wr(ins, a); tw_wr(dat, dack); tw_stop();
  endtask

  task automatic reg_rd(input logic [7:0] ins, output logic [7:0] dat);
    bit a;
    tw_start(); tw_wr(8'h58, a); tw_wr(ins, a);
    tw_start(); tw_wr(8'h59, a); tw_rd(dat); tw_stop();
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
    qw();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a0, a1, a2;
    logic [7:0] rd, cur0, cur1, v;
    int b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wprot = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2 reset state
    check("R2 wipers", wiper, 16'h4020);
    check("R2 busy", nv_busy, 0);
    check("R2 sda", sda_pull, 0);
    reg_rd(8'h80, rd); check("R2 ctrl", rd, 0);
    reg_rd(8'h41, rd); check("R2 shadow1", rd, 8'h40);
    cur0 = 8'h20; cur1 = 8'h40;

    // R1 addressing
    tw_start(); tw_wr(8'h5A, a0); tw_stop(); check("R1 foreign addr nack", a0, 0);
    tw_start(); tw_wr(8'h58, a0); tw_stop(); check("R1 own addr ack", a0, 1);

    // R7 no enable latch
    xfer_wr(8'h00, 8'h77, a2);
    check("R7 data acked", a2, 1);
    check("R7 wiper kept", wiper[7:0], cur0);

    // R8 set enable latch, no busy
    xfer_wr(8'h80, 8'h01, a2);
    check("R8 latch no busy", nv_busy, 0);
    reg_rd(8'h80, rd); check("R8 wel set", rd, 8'h01);

    // R3 volatile sweep
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 2; k++) begin
        v = 8'(37 * (k + 1) + d * 101);
        xfer_wr(8'(d), v, a2);
        check("R3 wiper", wiper[d*8 +: 8], v);
        reg_rd(8'(d), rd); check("R11 read wiper", rd, v);
        reg_rd(8'(8'h40 | d), rd); check("R3 shadow unchanged", rd, (d == 0) ? 8'h20 : 8'h40);
        if (d == 0) cur0 = v; else cur1 = v;
      end
    end

    // R4/R5 nonvolatile write and busy
    b0 = total_busy;
    xfer_wr(8'h41, 8'h99, a2);
    check("R4 busy after stop", nv_busy, 1);
    tw_start(); tw_wr(8'h58, a0); tw_stop(); check("R5 nack while busy", a0, 0);
    wait_idle();
    check("R4 busy length", total_busy - b0, NV);
    check("R4 wiper1", wiper[15:8], 8'h99);
    reg_rd(8'h41, rd); check("R4 shadow1", rd, 8'h99);
    tw_start(); tw_wr(8'h58, a0); tw_stop(); check("R5 ack after busy", a0, 1);
    cur1 = 8'h99;

    // R6 extra data bytes
    tw_start(); tw_wr(8'h58, a0); tw_wr(8'h00, a0); tw_wr(8'h3C, a1); tw_wr(8'hC3, a2); tw_stop();
    check("R6 first acked", a1, 1);
    check("R6 second nacked", a2, 0);
    check("R6 wiper", wiper[7:0], 8'h3C);
    cur0 = 8'h3C;
    reg_rd(8'h02, rd); check("R11 reserved reads zero", rd, 0);
    xfer_wr(8'h02, 8'h55, a2); check("R11 reserved no write", wiper, {cur1, cur0});

    // R8 register-write latch needs enable latch
    xfer_wr(8'h80, 8'h00, a2);
    xfer_wr(8'h80, 8'h02, a2);
    reg_rd(8'h80, rd); check("R8 rwel needs wel", rd, 0);
    xfer_wr(8'h80, 8'h01, a2);
    xfer_wr(8'h80, 8'h02, a2);
    reg_rd(8'h80, rd); check("R8 both latches", rd, 8'h03);

    // R10 lock write blocked by pin
    wprot = 1'b1;
    xfer_wr(8'h80, 8'h05, a2);
    check("R10 lock write no busy", nv_busy, 0);
    reg_rd(8'h80, rd); check("R10 lock not set", rd, 8'h01);
    wprot = 1'b0;

    // R9/R10/R7 protection sweep
    for (int c = 0; c < 8; c++) begin
      bit lk, wp, we;
      lk = c[2]; wp = c[1]; we = c[0];
      xfer_wr(8'h80, 8'h00, a2);
      if (lk) begin
        xfer_wr(8'h80, 8'h01, a2);
        xfer_wr(8'h80, 8'h02, a2);
        xfer_wr(8'h80, 8'h05, a2);
        check("R8 lock write busy", nv_busy, 1);
        wait_idle();
      end
      wprot = wp;
      xfer_wr(8'h80, we ? 8'h01 : 8'h00, a2);
      reg_rd(8'h80, rd);
      check("R10 latch with pin", rd, {5'b0, lk, 1'b0, we});
      v = 8'(8'h10 + c * 8'h11);
      xfer_wr(8'h00, v, a2);
      check("R9 data acked", a2, 1);
      if (we && !lk && !wp) cur0 = v;
      check(lk ? "R9 locked write" : (wp ? "R10 pin write" : "R7 enable write"), wiper[7:0], cur0);
      wprot = 1'b0;
      if (lk) begin
        xfer_wr(8'h80, 8'h01, a2);
        xfer_wr(8'h80, 8'h02, a2);
        xfer_wr(8'h80, 8'h01, a2);
        wait_idle();
        reg_rd(8'h80, rd); check("R8 lock cleared", rd, 8'h01);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule